// File: doc/BRIEF.md
# Status-Memory Command Sequencer

This block is the byte-level command engine of a slave device on a single-wire bus. It holds an eight-byte, one-time-programmable status field and serves two host commands. A bit-level time-slot front end, which is not part of this block, delivers whole received bytes, asks for transmit bytes, and flags bus reset pulses. The block answers each transmit request with the next byte of the sequence on the following clock cycle.

The status read takes a two-byte start address. It first returns a CRC-8 over what it received. It then streams the status bytes from the start address to the end of the field, follows them with a CRC-8 over exactly the bytes it sent, and then returns all-ones. The status write takes an address and a data byte and returns a CRC-8 over the four received bytes. After that it waits for a program-confirm byte. A later programming-pulse strobe then clears the stored bits wherever the data byte holds a zero. A bus reset pulse abandons any sequence at any point.

Top module: `status_cmd_seq`

## Requirements
- R1: After `rst_n` is released, `tx_byte` reads FFh. Status bytes 0 to 6 hold FFh and byte 7 holds 00h.
- R2: A received AAh followed by an address low byte and then an address high byte makes the next transmit request return the CRC of those three bytes. The CRC is CRC-8 with polynomial x^8+x^5+x^4+1, taken least-significant bit first from an initial value of 00h (reflected form: shift right, XOR 8Ch on feedback). Each transmitted byte appears on `tx_byte` in the cycle after the clock edge that samples `tx_req`.
- R3: On a read whose address is at most 7, the requests after the header CRC return the status bytes from address bits [2:0] up to byte 7. The next request returns the CRC of exactly those bytes, computed from 00h.
- R4: After the read data CRC, every request returns FFh until a bus reset.
- R5: On a read whose address is above 7 (nonzero high byte, or low byte above 7), the request after the header CRC returns 00h, which is the data CRC over no bytes. FFh follows.
- R6: A received 55h, address low, address high and data byte makes the next request return the CRC of those four bytes.
- R7: After the write CRC, a received 5Ah followed by a `prog_pulse` strobe replaces the addressed byte with (stored AND data). Byte 7 stays 00h.
- R8: A write leaves the status field unchanged if the address is above 7, if the byte after the CRC is not 5Ah, or if no `prog_pulse` arrives before the bus reset. After such a case only a bus reset restarts the engine.
- R9: `bus_reset` returns the engine to command-idle from any state. It takes priority over a `prog_pulse` or a received byte in the same cycle, and that pulse then writes nothing.
- R10: A command byte other than AAh or 55h makes the engine ignore all further bytes until a bus reset. Any request made while no byte is due returns FFh.
- R11: `tx_byte` holds its value in every cycle without a transmit request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restores the status field and the engine |
| bus_reset | input | 1 | One-cycle strobe: a bus reset pulse was seen |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte, bit 0 first on the wire |
| tx_req | input | 1 | One-cycle strobe: the front end needs the next byte to send |
| prog_pulse | input | 1 | One-cycle strobe: the programming pulse has been applied |
| tx_byte | output | 8 | Byte answering the last transmit request |

## Verification
The critical collision is a bus reset in the same cycle as the programming-pulse strobe while a confirmed write is armed. The reset must win, and the stored byte must be left untouched. The bench arms a write with 5Ah, raises both strobes on one clock edge, and then reads the whole field back through a fresh status read to compare against its own model. A second overlap, a received byte arriving while the engine is transmitting, is provoked during unknown-command handling and judged by the all-ones replies.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int STAT_BYTES = 8;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = $clog2(STAT_BYTES);

    localparam logic [BYTE_W-1:0] OP_READ    = 8'hAA;
    localparam logic [BYTE_W-1:0] OP_WRITE   = 8'h55;
    localparam logic [BYTE_W-1:0] OP_CONFIRM = 8'h5A;
    localparam logic [BYTE_W-1:0] ERASED     = 8'hFF;
    localparam logic [BYTE_W-1:0] FIXED_LAST = 8'h00;
    localparam logic [BYTE_W-1:0] IDLE_FILL  = 8'hFF;
    localparam logic [7:0]        POLY_REFL  = 8'h8C;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADR_LO,
        ST_ADR_HI,
        ST_DATA,
        ST_HDR_CRC,
        ST_RD_DATA,
        ST_RD_CRC,
        ST_RD_ONES,
        ST_CONFIRM,
        ST_ARMED,
        ST_PARK
    } seq_state_e;

    typedef struct packed {
        seq_state_e        st;
        logic              wr_mode;
        logic [7:0]        crc;
        logic [BYTE_W-1:0] alo;
        logic [BYTE_W-1:0] ahi;
        logic [BYTE_W-1:0] dat;
        logic [IDX_W-1:0]  ptr;
        logic [BYTE_W-1:0] tx;
    } seq_regs_t;
endpackage

// File: rtl/sq_crc8.sv
module sq_crc8 #(
    parameter int DW = 8
) (
    input  logic [7:0]    crc_in,
    input  logic [DW-1:0] data_in,
    output logic [7:0]    crc_out
);
    import sq_pkg::*;

    logic [7:0] chain [DW+1];

    assign chain[0] = crc_in;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic fb;
        assign fb = chain[b][0] ^ data_in[b];
        assign chain[b+1] = {1'b0, chain[b][7:1]} ^ (fb ? POLY_REFL : 8'h00);
    end

    assign crc_out = chain[DW];
endmodule

// File: rtl/sq_status_store.sv
module sq_status_store
    import sq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] mem_q [STAT_BYTES];
    logic [BYTE_W-1:0] mem_d [STAT_BYTES];

    for (genvar i = 0; i < STAT_BYTES; i++) begin : g_cell
        if (i == STAT_BYTES - 1) begin : g_fixed
            assign mem_d[i] = FIXED_LAST;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mem_q[i] <= FIXED_LAST;
                else        mem_q[i] <= mem_d[i];
            end
        end else begin : g_otp
            always_comb begin
                mem_d[i] = mem_q[i];
                if (wr_en && (wr_idx == IDX_W'(i)))
                    mem_d[i] = mem_q[i] & wr_data;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mem_q[i] <= ERASED;
                else        mem_q[i] <= mem_d[i];
            end
        end

        // R7: a stored bit can only go from 1 to 0
        a_r7_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((mem_q[i] & ~$past(mem_q[i])) == '0));
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/sq_cmd_fsm.sv
module sq_cmd_fsm
    import sq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset_i,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              tx_req_i,
    input  logic              prog_pulse_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [BYTE_W-1:0] tx_byte_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STAT_BYTES - 1);

    seq_regs_t s_q, s_d;

    logic [7:0]        crc_base;
    logic [BYTE_W-1:0] crc_data;
    logic [7:0]        crc_next;
    logic              addr_ok;

    // one stepper: received bytes, or the byte being sent during a read
    assign crc_base = (s_q.st == ST_IDLE) ? 8'h00 : s_q.crc;
    assign crc_data = (s_q.st == ST_RD_DATA) ? rd_data_i : rx_byte_i;

    sq_crc8 #(.DW(BYTE_W)) u_crc (
        .crc_in  (crc_base),
        .data_in (crc_data),
        .crc_out (crc_next)
    );

    assign addr_ok = (s_q.alo[BYTE_W-1:IDX_W] == '0) && (s_q.ahi == '0);

    always_comb begin
        s_d     = s_q;
        wr_en_o = 1'b0;
        if (tx_req_i) s_d.tx = IDLE_FILL;

        if (bus_reset_i) begin
            s_d.st      = ST_IDLE;
            s_d.wr_mode = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_IDLE: if (rx_valid_i) begin
                    s_d.crc = crc_next;
                    if (rx_byte_i == OP_READ) begin
                        s_d.st      = ST_ADR_LO;
                        s_d.wr_mode = 1'b0;
                    end else if (rx_byte_i == OP_WRITE) begin
                        s_d.st      = ST_ADR_LO;
                        s_d.wr_mode = 1'b1;
                    end else begin
                        s_d.st = ST_PARK;
                    end
                end
                ST_ADR_LO: if (rx_valid_i) begin
                    s_d.alo = rx_byte_i;
                    s_d.crc = crc_next;
                    s_d.st  = ST_ADR_HI;
                end
                ST_ADR_HI: if (rx_valid_i) begin
                    s_d.ahi = rx_byte_i;
                    s_d.crc = crc_next;
                    s_d.st  = s_q.wr_mode ? ST_DATA : ST_HDR_CRC;
                end
                ST_DATA: if (rx_valid_i) begin
                    s_d.dat = rx_byte_i;
                    s_d.crc = crc_next;
                    s_d.st  = ST_HDR_CRC;
                end
                ST_HDR_CRC: if (tx_req_i) begin
                    s_d.tx  = s_q.crc;
                    s_d.crc = 8'h00;
                    s_d.ptr = s_q.alo[IDX_W-1:0];
                    if (s_q.wr_mode)  s_d.st = ST_CONFIRM;
                    else if (addr_ok) s_d.st = ST_RD_DATA;
                    else              s_d.st = ST_RD_CRC;
                end
                ST_RD_DATA: if (tx_req_i) begin
                    s_d.tx  = rd_data_i;
                    s_d.crc = crc_next;
                    if (s_q.ptr == LAST_IDX) s_d.st = ST_RD_CRC;
                    else                     s_d.ptr = s_q.ptr + 1'b1;
                end
                ST_RD_CRC: if (tx_req_i) begin
                    s_d.tx = s_q.crc;
                    s_d.st = ST_RD_ONES;
                end
                ST_CONFIRM: if (rx_valid_i) begin
                    s_d.st = ((rx_byte_i == OP_CONFIRM) && addr_ok) ? ST_ARMED : ST_PARK;
                end
                ST_ARMED: if (prog_pulse_i) begin
                    wr_en_o = 1'b1;
                    s_d.st  = ST_PARK;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.st      <= ST_IDLE;
            s_q.tx      <= IDLE_FILL;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_idx_o  = s_q.ptr;
    assign wr_idx_o  = s_q.alo[IDX_W-1:0];
    assign wr_data_o = s_q.dat;
    assign tx_byte_o = s_q.tx;

    // R9: a bus reset always lands in command-idle
    a_r9_reset_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> (s_q.st == ST_IDLE));

    // R4: after the data CRC the answers are all-ones
    a_r4_ones_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RD_ONES && tx_req_i && !bus_reset_i) |=> (tx_byte_o == IDLE_FILL));

    // R11: the transmit byte moves only on a request
    a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req_i |=> $stable(tx_byte_o));

    // R8: a store write happens only out of the armed state
    a_r8_write_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (s_q.st == ST_PARK && $past(s_q.st) == ST_ARMED));
endmodule

// File: rtl/status_cmd_seq.sv
module status_cmd_seq
    import sq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_req,
    input  logic              prog_pulse,
    output logic [BYTE_W-1:0] tx_byte
);
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;

    sq_cmd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_reset_i  (bus_reset),
        .rx_valid_i   (rx_valid),
        .rx_byte_i    (rx_byte),
        .tx_req_i     (tx_req),
        .prog_pulse_i (prog_pulse),
        .rd_data_i    (rd_data),
        .rd_idx_o     (rd_idx),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .wr_data_o    (wr_data),
        .tx_byte_o    (tx_byte)
    );

    sq_status_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // R9: a programming pulse coinciding with a bus reset writes nothing
    a_r9_reset_beats_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> !wr_en);
endmodule

// File: tb/status_cmd_seq_tb.sv
module status_cmd_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       prog_pulse = 1'b0;
    logic [7:0] tx_byte;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [7:0] model [8];

    always #2 clk = ~clk;

    status_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .prog_pulse(prog_pulse), .tx_byte(tx_byte)
    );

    function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int k = 0; k < 8; k++) begin
            if ((r[0] ^ d[k]) == 1'b1) r = (r >> 1) ^ 8'h8C;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic strobe_reset();
        @(negedge clk) bus_reset = 1'b1;
        @(negedge clk) bus_reset = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
        @(negedge clk) rx_valid = 1'b0;
    endtask

    task automatic fetch(output logic [7:0] b);
        @(negedge clk) tx_req = 1'b1;
        @(negedge clk) tx_req = 1'b0;
        b = tx_byte;
    endtask

    task automatic pulse();
        @(negedge clk) prog_pulse = 1'b1;
        @(negedge clk) prog_pulse = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] lo, input logic [7:0] hi);
        logic [7:0] got, c;
        strobe_reset();
        send(8'hAA); send(lo); send(hi);
        c = crc_add(crc_add(crc_add(8'h00, 8'hAA), lo), hi);
        fetch(got); check("R2 header crc", got, c);
        c = 8'h00;
        if (hi == 8'h00 && lo < 8) begin
            for (int p = int'(lo); p < 8; p++) begin
                fetch(got); check("R3 data byte", got, model[p]);
                c = crc_add(c, model[p]);
            end
            fetch(got); check("R3 data crc", got, c);
        end else begin
            fetch(got); check("R5 empty data crc", got, 8'h00);
        end
        for (int k = 0; k < 2; k++) begin
            fetch(got); check("R4 ones tail", got, 8'hFF);
        end
    endtask

    task automatic do_write(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] d,
                            input logic [7:0] conf, input bit give_pulse);
        logic [7:0] got, c;
        strobe_reset();
        send(8'h55); send(lo); send(hi); send(d);
        c = crc_add(crc_add(crc_add(crc_add(8'h00, 8'h55), lo), hi), d);
        fetch(got); check("R6 write crc", got, c);
        send(conf);
        if (give_pulse) pulse();
        if (give_pulse && conf == 8'h5A && hi == 8'h00 && lo < 7)
            model[lo[2:0]] = model[lo[2:0]] & d;
        strobe_reset();
    endtask

    initial begin
        logic [7:0] got, held;
        for (int i = 0; i < 7; i++) model[i] = 8'hFF;
        model[7] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset tx_byte", tx_byte, 8'hFF);
        do_read(8'h00, 8'h00);  // R1 erased field, fixed last byte

        // R2 R3 R4: every start address
        for (int a = 0; a < 8; a++) do_read(8'(a), 8'h00);
        // R5: addresses beyond the field
        do_read(8'h08, 8'h00);
        do_read(8'hF3, 8'h00);
        do_read(8'h02, 8'h01);

        // R6 R7: program each byte, then accumulate a second pattern
        for (int a = 0; a < 8; a++) do_write(8'(a), 8'h00, ~(8'h01 << a), 8'h5A, 1'b1);
        do_read(8'h00, 8'h00);
        for (int a = 0; a < 8; a++) do_write(8'(a), 8'h00, 8'hF0 ^ 8'(a * 8'h11), 8'h5A, 1'b1);
        do_read(8'h00, 8'h00);

        // R8: bad confirm, missing pulse, out-of-range address
        do_write(8'h01, 8'h00, 8'h00, 8'h5B, 1'b1);
        do_write(8'h02, 8'h00, 8'h00, 8'h5A, 1'b0);
        do_write(8'h09, 8'h00, 8'h00, 8'h5A, 1'b1);
        do_write(8'h03, 8'h01, 8'h00, 8'h5A, 1'b1);
        do_read(8'h00, 8'h00);

        // R9: reset and pulse in the same cycle
        strobe_reset();
        send(8'h55); send(8'h04); send(8'h00); send(8'h00);
        fetch(got); send(8'h5A);
        @(negedge clk) begin bus_reset = 1'b1; prog_pulse = 1'b1; end
        @(negedge clk) begin bus_reset = 1'b0; prog_pulse = 1'b0; end
        pulse();  // engine is idle now: no effect
        do_read(8'h04, 8'h00);
        // R9: abort mid-read, then a fresh read
        strobe_reset();
        send(8'hAA); send(8'h00); send(8'h00); fetch(got); fetch(got);
        do_read(8'h05, 8'h00);

        // R10: unknown command, then overlapping byte and request
        strobe_reset();
        send(8'h33);
        fetch(got); check("R10 unknown cmd", got, 8'hFF);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = 8'hAA; tx_req = 1'b1; end
        @(negedge clk) begin rx_valid = 1'b0; tx_req = 1'b0; end
        check("R10 parked overlap", tx_byte, 8'hFF);
        send(8'h00); send(8'h00);
        fetch(got); check("R10 still parked", got, 8'hFF);
        // R10: request in idle
        strobe_reset();
        fetch(got); check("R10 idle request", got, 8'hFF);

        // R11: hold without request
        strobe_reset();
        send(8'hAA); send(8'h00); send(8'h00);
        fetch(held);
        repeat (5) @(negedge clk);
        check("R11 tx hold", tx_byte, held);
        send(8'h12);
        check("R11 hold over rx", tx_byte, held);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule